// File: doc/BRIEF.md
# Transform Block Input Framer

This block sits in front of a DFT/IDFT kernel. It takes complex integer samples from a valid/ready streaming sink and groups them into transform blocks. The transform length does not arrive on every beat. A side input carries it, and the block samples that input only on the beat that opens a block (start-of-packet asserted while the framer waits for a new block). The block then counts accepted samples up to that length to find where the block ends. The end-of-packet input plays no part in framing.

A parameter sets the number of complex samples per beat to one or three, and the data buses widen by that factor. The sink handshake has a ready latency of one: a beat is taken when valid is high and ready was high in the previous cycle. Ready follows the kernel's busy input with a one-cycle delay, so after ready drops, one more beat can still be accepted. A length outside the supported set raises a sticky error and discards that whole block. Accepted samples come out one cycle later on registered outputs, marked with first and last strobes and the captured length.

Top module: `blkfrm_top`

## Requirements
- R1: While reset is asserted and in the cycle it is released, `in_ready`, `out_valid` and `len_err` are all 0.
- R2: A beat is accepted only when `in_valid` is 1 in that cycle and `in_ready` was 1 in the previous cycle. A beat with `in_valid` high in any other cycle has no effect.
- R3: `in_ready` in each cycle is the inverse of `kern_busy` in the previous cycle. Because of the ready latency, the beat in the first cycle with `in_ready` low is still accepted.
- R4: The 12-bit straight-binary `in_len` is captured only from the accepted beat that opens a block. Values on later beats of the block have no effect, and `out_len` keeps the captured length on every output beat of the block.
- R5: A length is supported when it equals 12·2^a·3^b·5^c (a, b, c ≥ 0) and is at most 3240. This gives 53 sizes from 12 to 3240.
- R6: An opening beat that carries an unsupported length sets `len_err`. The flag stays at 1 until reset. That beat and every following beat up to the next accepted start-of-packet produce no output.
- R7: Each accepted beat of a block adds LANES samples to the count. `out_last` is 1 on the beat that brings the count to the captured length. The framer then waits for a new opening beat.
- R8: `in_eop` has no effect on framing or outputs.
- R9: While the framer waits for a new block, accepted beats with `in_sop` = 0 are dropped. `in_sop` on beats inside a block is ignored.
- R10: Each accepted beat of a valid block appears on `out_re`/`out_im` one cycle later with `out_valid` = 1. `out_first` is 1 only on the opening beat. `out_valid` is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kern_busy | input | 1 | Downstream kernel cannot take samples |
| in_valid | input | 1 | Sink beat valid |
| in_ready | output | 1 | Sink ready, latency 1 |
| in_sop | input | 1 | Beat opens a block |
| in_eop | input | 1 | End-of-packet, ignored |
| in_len | input | 12 | Transform length, binary |
| in_re | input | LANES*DW | Real parts, lane 0 in low bits |
| in_im | input | LANES*DW | Imaginary parts, lane 0 in low bits |
| out_valid | output | 1 | Output beat valid |
| out_first | output | 1 | First beat of block |
| out_last | output | 1 | Last beat of block |
| out_len | output | 12 | Captured block length |
| out_re | output | LANES*DW | Real parts |
| out_im | output | LANES*DW | Imaginary parts |
| len_err | output | 1 | Sticky unsupported-length flag |

## Verification
The bench builds the block with LANES = 3 and DW = 16. With three lanes the counter steps by three, so the last-beat comparison is tested on an increment that is not one. The maximum size of 3240 takes 1080 beats and uses the full 12-bit length range. The bench varies the chance of a beat being valid and of the kernel being busy. This exercises the ready-latency case, where a beat arrives in the cycle after ready falls, as well as sustained stalls. It also mixes in blocks of both the minimum and maximum size and several unsupported lengths.

// File: rtl/blkfrm_pkg.sv
package blkfrm_pkg;
  localparam int LEN_W   = 12;
  localparam int MIN_LEN = 12;
  localparam int MAX_LEN = 3240;

  typedef logic [LEN_W-1:0] len_t;

  // True when l = 12 * 2^a * 3^b * 5^c and l <= MAX_LEN
  function automatic logic len_supported(input len_t l);
    len_t q;
    if (l < len_t'(MIN_LEN) || l > len_t'(MAX_LEN) || (l % len_t'(12)) != '0)
      return 1'b0;
    q = l / len_t'(12);
    for (int i = 0; i < 9; i++)
      if (q[0] == 1'b0) q = q >> 1;
    for (int i = 0; i < 5; i++)
      if ((q % len_t'(3)) == '0) q = q / len_t'(3);
    for (int i = 0; i < 4; i++)
      if ((q % len_t'(5)) == '0) q = q / len_t'(5);
    return q == len_t'(1);
  endfunction
endpackage

// File: rtl/blkfrm_lencheck.sv
module blkfrm_lencheck
  import blkfrm_pkg::*;
(
  input  len_t len,
  output logic ok
);
  always_comb ok = len_supported(len);
endmodule

// File: rtl/blkfrm_hshk.sv
module blkfrm_hshk (
  input  logic clk,
  input  logic rst,
  input  logic kern_busy,
  input  logic in_valid,
  output logic in_ready,
  output logic accept
);
  logic ready_r;
  logic ready_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_r    <= 1'b0;
      ready_prev <= 1'b0;
    end else begin
      ready_r    <= ~kern_busy;
      ready_prev <= ready_r;
    end
  end

  assign in_ready = ready_r;
  assign accept   = in_valid & ready_prev;

  // R2: an accepted beat needs the ready advertised in the prior cycle
  p_accept_prior_ready_r2: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(in_ready));
endmodule

// File: rtl/blkfrm_count.sv
module blkfrm_count
  import blkfrm_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic in_sop,
  input  logic in_eop,
  input  len_t in_len,
  input  logic len_ok,
  output logic start,
  output logic mid,
  output logic last,
  output len_t frame_len,
  output logic err
);
  localparam len_t STEP = len_t'(LANES);

  logic hunting;
  len_t cnt;
  len_t len_q;
  len_t nxt;
  logic bad;

  always_comb begin
    start     = accept & hunting & in_sop & len_ok;
    bad       = accept & hunting & in_sop & ~len_ok;
    mid       = accept & ~hunting;
    nxt       = cnt + STEP;
    last      = mid & (nxt == len_q);
    frame_len = start ? in_len : len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hunting <= 1'b1;
      cnt     <= '0;
      len_q   <= '0;
      err     <= 1'b0;
    end else begin
      if (bad) err <= 1'b1;
      if (start) begin
        hunting <= 1'b0;
        cnt     <= STEP;
        len_q   <= in_len;
      end else if (mid) begin
        cnt <= nxt;
        if (last) hunting <= 1'b1;
      end
    end
  end

  // R7: inside a block the count never reaches the captured length
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    !hunting |-> (cnt < len_q));
  // R6: the error flag never clears outside reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R8: end-of-packet on a non-final beat leaves the block open
  p_eop_no_end_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && in_eop && !hunting && !last) |=> !hunting);
endmodule

// File: rtl/blkfrm_top.sv
module blkfrm_top
  import blkfrm_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DW    = 16,
  localparam int BW   = LANES * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kern_busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [LEN_W-1:0] in_len,
  input  logic [BW-1:0]    in_re,
  input  logic [BW-1:0]    in_im,
  output logic             out_valid,
  output logic             out_first,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic [BW-1:0]    out_re,
  output logic [BW-1:0]    out_im,
  output logic             len_err
);
  logic accept, len_ok, start, mid, last;
  len_t frame_len;

  generate
    if (LANES != 1 && LANES != 3) begin : g_bad_lanes
      initial $error("LANES must be 1 or 3");
    end
  endgenerate

  blkfrm_hshk u_hshk (
    .clk(clk), .rst(rst), .kern_busy(kern_busy),
    .in_valid(in_valid), .in_ready(in_ready), .accept(accept)
  );

  blkfrm_lencheck u_lchk (.len(in_len), .ok(len_ok));

  blkfrm_count #(.LANES(LANES)) u_cnt (
    .clk(clk), .rst(rst), .accept(accept), .in_sop(in_sop),
    .in_eop(in_eop), .in_len(in_len), .len_ok(len_ok),
    .start(start), .mid(mid), .last(last),
    .frame_len(frame_len), .err(len_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_len   <= '0;
    end else begin
      out_valid <= start | mid;
      out_first <= start;
      out_last  <= last;
      if (start | mid) out_len <= frame_len;
    end
  end

  always_ff @(posedge clk) begin
    if (start | mid) begin
      out_re <= in_re;
      out_im <= in_im;
    end
  end

  // R3: busy three cycles back blocks any output now
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$past(kern_busy, 3));
  // R5: an opening output beat always carries a supported length
  p_first_len_ok_r5: assert property (@(posedge clk) disable iff (rst)
    out_first |-> len_supported(out_len));
  // R10: strobes only on valid beats
  p_strobe_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (out_first || out_last) |-> out_valid);
  // R7: a block is never opened and closed on the same beat
  p_first_not_last_r7: assert property (@(posedge clk) disable iff (rst)
    out_first |-> !out_last);
endmodule

// File: tb/tb_blkfrm_top.sv
`timescale 1ns/1ps
module tb_blkfrm_top;
  localparam int LANES = 3;
  localparam int DW    = 16;
  localparam int BW    = LANES * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kern_busy = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [11:0] in_len = '0;
  logic [BW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_first, out_last, len_err;
  logic [11:0] out_len;
  logic [BW-1:0] out_re, out_im;

  always #2.5 clk = ~clk;

  blkfrm_top #(.LANES(LANES), .DW(DW)) dut (
    .clk(clk), .rst(rst), .kern_busy(kern_busy), .in_valid(in_valid),
    .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_len(in_len),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_first(out_first),
    .out_last(out_last), .out_len(out_len), .out_re(out_re), .out_im(out_im),
    .len_err(len_err)
  );

  int nchk = 0, nfail = 0;
  string ph = "R10";
  int ok_tab[64];
  int ok_n = 0;

  // model state
  logic r_prev, r_cur, r_nxt;
  logic m_hunt;
  int   m_cnt, m_len;
  logic e_valid, e_first, e_last, e_err;
  logic [11:0] e_len;
  logic [BW-1:0] e_re, e_im;

  function automatic bit size_ok(int l);
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 4; c++) begin
          longint v = 12 * (64'd1 << a);
          for (int k = 0; k < b; k++) v = v * 3;
          for (int k = 0; k < c; k++) v = v * 5;
          if (v == l && v <= 3240) return 1'b1;
        end
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic sop, input logic eop,
                      input logic [11:0] len, input logic busy, output logic acc);
    logic [BW-1:0] dre, dim;
    @(negedge clk);
    r_prev = r_cur;
    r_cur  = r_nxt;
    chk("R3", "in_ready", in_ready, r_cur);
    chk(ph, "out_valid", out_valid, e_valid);
    chk("R6", "len_err", len_err, e_err);
    if (e_valid) begin
      chk("R10", "out_first", out_first, e_first);
      chk("R7", "out_last", out_last, e_last);
      chk("R4", "out_len", out_len, e_len);
      chk("R10", "out_re", out_re, e_re);
      chk("R10", "out_im", out_im, e_im);
    end
    dre = BW'({$urandom(), $urandom()});
    dim = BW'({$urandom(), $urandom()});
    in_valid = v; in_sop = sop; in_eop = eop; in_len = len;
    in_re = dre; in_im = dim; kern_busy = busy;
    acc = v & r_prev;
    r_nxt = ~busy;
    e_valid = 1'b0; e_first = 1'b0; e_last = 1'b0;
    if (acc) begin
      if (m_hunt) begin
        if (sop) begin
          if (size_ok(int'(len))) begin
            m_hunt = 1'b0; m_len = int'(len); m_cnt = LANES;
            e_valid = 1'b1; e_first = 1'b1; e_len = len;
            e_re = dre; e_im = dim;
          end else e_err = 1'b1;
        end
      end else begin
        m_cnt += LANES;
        e_valid = 1'b1; e_len = 12'(m_len);
        e_re = dre; e_im = dim;
        if (m_cnt == m_len) begin e_last = 1'b1; m_hunt = 1'b1; end
      end
    end
  endtask

  // send nbeats beats opened with length len; pv/pb/pe percentages
  task automatic send_block(input int len, input int nbeats, input int pv,
                            input int pb, input int pe);
    int idx = 0;
    logic acc;
    while (idx < nbeats) begin
      logic v = (($urandom() % 100) < pv);
      logic [11:0] l = (idx == 0) ? 12'(len) : 12'($urandom());
      step(v, idx == 0, (($urandom() % 100) < pe), l, (($urandom() % 100) < pb), acc);
      if (acc) idx++;
    end
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 12'd0, 1'b0, acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic acc;
    void'($urandom(32'd2024));
    for (int l = 1; l <= 3300; l++) if (size_ok(l)) begin ok_tab[ok_n] = l; ok_n++; end
    chk("R5", "supported size count", ok_n, 53);
    repeat (4) @(negedge clk);
    // R1: reset state, including the cycle reset is released
    chk("R1", "in_ready in reset", in_ready, 0);
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "len_err in reset", len_err, 0);
    rst = 1'b0;
    r_cur = 1'b0; r_nxt = 1'b1; m_hunt = 1'b1; m_cnt = 0; m_len = 0;
    e_valid = 0; e_first = 0; e_last = 0; e_err = 0; e_len = '0; e_re = '0; e_im = '0;
    step(1'b1, 1'b1, 1'b0, 12'd12, 1'b0, acc);
    chk("R1", "beat right after reset not accepted", acc, 0);
    idle(2);
    // directed: minimum and maximum sizes, full rate
    ph = "R7";
    send_block(12, 4, 100, 0, 0);
    send_block(3240, 1080, 100, 0, 0);
    idle(3);
    // R3: busy toggling at full input rate
    ph = "R3";
    send_block(120, 40, 100, 40, 0);
    idle(3);
    // R9: beats without sop while hunting are dropped
    ph = "R9";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 12'd24, 1'b0, acc);
    send_block(24, 8, 100, 0, 0);
    // R5 / R6: unsupported lengths, then more beats, then a good block
    ph = "R5";
    send_block(13, 5, 80, 10, 0);
    send_block(3252, 3, 100, 0, 0);
    send_block(1176, 4, 100, 0, 0);
    send_block(0, 2, 100, 0, 0);
    send_block(2046, 2, 100, 0, 0);
    send_block(36, 12, 100, 0, 0);
    // R8: random eop, random sizes, random gaps and stalls
    ph = "R8";
    for (int b = 0; b < 40; b++) begin
      int l;
      do l = ok_tab[$urandom() % ok_n]; while (l > 900);
      send_block(l, l / LANES, 30 + ($urandom() % 71), $urandom() % 50, 30);
      if (($urandom() % 4) == 0) idle($urandom() % 4);
    end
    // R2 / R4: back-to-back blocks with random lengths on inner beats
    ph = "R2";
    send_block(48, 16, 60, 20, 0);
    send_block(60, 20, 100, 0, 0);
    ph = "R4";
    send_block(72, 24, 90, 10, 0);
    idle(4);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule